// File: doc/BRIEF.md
# Programmable Countdown Timer with Expiry Request

This block is the countdown timer that sits beside a processor's local interrupt unit. Software programs a start value, a clock divider and a timer entry that holds the vector, a mask bit and a mode bit. The counter then steps down once per divided clock period. In one-shot mode it stops at zero. In periodic mode it reloads the start value and runs again.

Each time the count lands on zero, the block raises a single-cycle expiry request and presents the entry's vector with it. The mask bit blocks this request. The interrupt priority logic that consumes the request lies outside this block.

Registers are written through a single-cycle write port. They are read through a separate combinational read port. The register codes, used on both ports, are:

- 0: timer entry
- 1: start value
- 2: live count
- 3: divider

Top module: `ctmr_top`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The start value, live count and divider read 0, and no expiry request is raised.
- R2: A write to the divider (code 3) keeps only data bits 0, 1 and 3. Bit 2 and bits 31:4 read back as 0.
- R3: The divider selects v = {bit3, bit1, bit0}. The live count steps down by exactly one every 2^((v+1) mod 8) clock cycles, so v = 7 steps every cycle. The first step comes that many cycles after the start value is written.
- R4: Writing the start value (code 1) loads the live count with that value in the next cycle. It also restarts the divided-clock phase, even while a count is in progress.
- R5: With the entry's mode bit (bit 17) clear, the live count steps down to 0 and then holds at 0.
- R6: With the mode bit set, the live count runs start, start−1, …, 0 and then reloads the start value. Each period is therefore start+1 divided-clock steps.
- R7: A write to the live count (code 2) changes nothing that can be observed.
- R8: When the live count steps from 1 to 0 and the entry is unmasked, the expiry output is high for exactly one cycle. This is the same cycle in which the live count first reads 0, and the vector output then carries entry bits 7:0.
- R9: While entry bit 16 (mask) is set, no expiry request is raised. Counting continues unchanged.
- R10: A start value of 0 leaves the timer stopped at 0, and no expiry request is raised.
- R11: The timer entry keeps bits 17, 16 and 7:0 of a write. All other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register code for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register code for the read |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| expire_o | output | 1 | One-cycle expiry request |
| expire_vec_o | output | 8 | Vector accompanying the request, 0 otherwise |

## Verification
A corrupt divider phase shows up as a live count that steps one or more cycles early or late, so it is visible within one divided period of the error. A wrong run flag or reload value is visible as soon as the count reaches zero. In that case the count either keeps moving past zero, freezes in periodic mode, or reloads the wrong value, and the expiry pulse moves or vanishes along with it. The bench reads the live count on almost every cycle and compares it against a behavioural model, so any of these faults is caught in the cycle where the count first diverges.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;
    localparam int CNT_W   = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int DIV_W   = 4;

    localparam logic [1:0] REG_ENTRY = 2'd0;
    localparam logic [1:0] REG_START = 2'd1;
    localparam logic [1:0] REG_LIVE  = 2'd2;
    localparam logic [1:0] REG_DIV   = 2'd3;

    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;

    typedef struct packed {
        logic             mask;
        logic             periodic;
        logic [VEC_W-1:0] vec;
        logic [CNT_W-1:0] start;
        logic [DIV_W-1:0] div;
    } regs_t;
endpackage

// File: rtl/ctmr_regs.sv
`timescale 1ns/1ps
module ctmr_regs
    import ctmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output regs_t              regs,
    output logic               load,
    output logic [SHIFT_W-1:0] shift
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                REG_ENTRY: begin
                    regs_d.mask     = wr_data[MASK_BIT];
                    regs_d.periodic = wr_data[MODE_BIT];
                    regs_d.vec      = wr_data[VEC_W-1:0];
                end
                REG_START: regs_d.start = wr_data;
                REG_DIV:   regs_d.div   = {wr_data[3], 1'b0, wr_data[1:0]};
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.mask <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs  = regs_q;
    assign load  = wr_en && (wr_addr == REG_START);
    assign shift = {regs_q.div[3], regs_q.div[1:0]} + SHIFT_W'(1);
endmodule

// File: rtl/ctmr_prescale.sv
`timescale 1ns/1ps
module ctmr_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            limit[i] = (i < int'(shift));
        end
        tick  = !restart && (cnt_q >= limit);
        cnt_d = (restart || tick) ? '0 : cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ctmr_count.sv
`timescale 1ns/1ps
module ctmr_count #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vec,
    output logic [CNT_W-1:0] cur,
    output logic             expire,
    output logic [VEC_W-1:0] expire_vec
);
    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             run;
        logic             irq;
        logic [VEC_W-1:0] vec;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cur = load_val;
            st_d.run = |load_val;
        end else if (tick && st_q.run) begin
            if (st_q.cur == '0) begin
                if (periodic) st_d.cur = start;
                else          st_d.run = 1'b0;
            end else begin
                st_d.cur = st_q.cur - CNT_W'(1);
                if (st_q.cur == CNT_W'(1)) begin
                    if (!periodic) st_d.run = 1'b0;
                    if (!mask) begin
                        st_d.irq = 1'b1;
                        st_d.vec = vec;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur        = st_q.cur;
    assign expire     = st_q.irq;
    assign expire_vec = st_q.irq ? st_q.vec : '0;
endmodule

// File: rtl/ctmr_top.sv
`timescale 1ns/1ps
module ctmr_top
    import ctmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        expire_o,
    output logic [7:0]  expire_vec_o
);
    regs_t              regs_w;
    logic               load_w;
    logic               tick_w;
    logic [SHIFT_W-1:0] shift_w;
    logic [CNT_W-1:0]   cur_w;

    ctmr_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs_w),
        .load    (load_w),
        .shift   (shift_w)
    );

    ctmr_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_w),
        .shift   (shift_w),
        .tick    (tick_w)
    );

    ctmr_count #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .load       (load_w),
        .load_val   (wr_data),
        .start      (regs_w.start),
        .periodic   (regs_w.periodic),
        .mask       (regs_w.mask),
        .vec        (regs_w.vec),
        .cur        (cur_w),
        .expire     (expire_o),
        .expire_vec (expire_vec_o)
    );

    always_comb begin
        case (rd_addr)
            REG_ENTRY: begin
                rd_data                = '0;
                rd_data[MODE_BIT]      = regs_w.periodic;
                rd_data[MASK_BIT]      = regs_w.mask;
                rd_data[VEC_W-1:0]     = regs_w.vec;
            end
            REG_START: rd_data = regs_w.start;
            REG_LIVE:  rd_data = cur_w;
            default:   rd_data = {{(32-DIV_W){1'b0}}, regs_w.div};
        endcase
    end
endmodule

// File: rtl/ctmr_chk.sv
`timescale 1ns/1ps
module ctmr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        expire,
    input logic [31:0] cur,
    input logic        mask,
    input logic        periodic,
    input logic [31:0] start,
    input logic        wr_start
);
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    assert_pulse_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (cur == 32'd0));

    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !$past(mask));

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != 32'd0 && !wr_start) |=> (cur == $past(cur) || cur == $past(cur) - 32'd1));

    assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && cur == 32'd0 && !wr_start) |=> (cur == 32'd0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start == 32'd0 && !wr_start) |=> (cur == 32'd0 && !expire));
endmodule

bind ctmr_top ctmr_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire_o),
    .cur      (cur_w),
    .mask     (regs_w.mask),
    .periodic (regs_w.periodic),
    .start    (regs_w.start),
    .wr_start (load_w)
);

// File: tb/ctmr_top_tb_top.sv
`timescale 1ns/1ps
module ctmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        expire_o;
    logic [7:0]  expire_vec_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_start, m_cur;
    bit          m_run, m_mask, m_per, m_irq;
    logic [7:0]  m_vec, m_ivec;
    logic [3:0]  m_div;
    int          m_pre;

    always #4 clk = ~clk;

    ctmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .expire_o(expire_o), .expire_vec_o(expire_vec_o)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%08h expected=0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] ra);
        case (ra)
            2'd0:    return {14'd0, m_per, m_mask, 8'd0, m_vec};
            2'd1:    return m_start;
            2'd2:    return m_cur;
            default: return {28'd0, m_div};
        endcase
    endfunction

    task automatic m_reset();
        m_start = 0; m_cur = 0; m_run = 0; m_mask = 1; m_per = 0;
        m_irq = 0; m_vec = 0; m_ivec = 0; m_div = 0; m_pre = 0;
    endtask

    // Behavioural model: advance one clock using the inputs being driven.
    task automatic m_step(input bit we, input logic [1:0] a, input logic [31:0] d);
        int v, ratio;
        bit tk, nirq;
        logic [7:0] niv;
        v = {m_div[3], m_div[1:0]};
        ratio = 1 << ((v + 1) % 8);
        nirq = 0; niv = 0;
        if (we && a == 2'd1) begin
            m_cur = d; m_run = (d != 0); m_pre = 0;
        end else begin
            if (m_pre + 1 >= ratio) begin tk = 1; m_pre = 0; end
            else begin tk = 0; m_pre = m_pre + 1; end
            if (tk && m_run) begin
                if (m_cur == 0) begin
                    if (m_per) m_cur = m_start; else m_run = 0;
                end else begin
                    m_cur = m_cur - 1;
                    if (m_cur == 0) begin
                        if (!m_per) m_run = 0;
                        if (!m_mask) begin nirq = 1; niv = m_vec; end
                    end
                end
            end
        end
        if (we) begin
            case (a)
                2'd0: begin m_mask = d[16]; m_per = d[17]; m_vec = d[7:0]; end
                2'd1: m_start = d;
                2'd3: m_div = d[3:0] & 4'hB;
                default: ;
            endcase
        end
        m_irq = nirq; m_ivec = niv;
    endtask

    // One clock: drive at negedge, compare at the next negedge.
    task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d,
                        input logic [1:0] ra, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        m_step(we, a, d);
        @(negedge clk);
        wr_en = 0;
        chk({31'd0, expire_o}, {31'd0, m_irq}, m_mask ? "R9 expire" : "R8 expire");
        chk({24'd0, expire_vec_o}, {24'd0, m_ivec}, "R8 vector");
        chk(rd_data, m_read(ra), tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 2'd0, 32'd0, 2'd2, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state of every register
        step(0, 2'd0, 0, 2'd0, "R1 entry reset");
        step(0, 2'd0, 0, 2'd1, "R1 start reset");
        step(0, 2'd0, 0, 2'd2, "R1 live reset");
        step(0, 2'd0, 0, 2'd3, "R1 divider reset");

        // R2: divider keeps bits 0,1,3
        step(1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R2 divider mask");
        step(1, 2'd3, 32'h0000_0004, 2'd3, "R2 divider bit2 dropped");
        step(1, 2'd3, 32'h0000_000B, 2'd3, "R2 divider 0xB");

        // R11: entry field retention
        step(1, 2'd0, 32'hFFFF_FFFF, 2'd0, "R11 entry fields");
        step(1, 2'd0, 32'h0000_0045, 2'd0, "R11 entry unmasked one-shot");

        // R5/R8: one-shot at divide-by-1
        step(1, 2'd1, 32'd5, 2'd2, "R4 load start");
        idle(10, "R5 one-shot count");

        // R6: periodic reload, divide-by-1
        step(1, 2'd0, 32'h0002_0033, 2'd0, "R11 periodic entry");
        step(1, 2'd1, 32'd3, 2'd2, "R4 load periodic");
        idle(14, "R6 periodic count");
        step(1, 2'd1, 32'd1, 2'd2, "R4 load periodic 1");
        idle(8, "R6 periodic start 1");

        // R3: divider rates (one-shot)
        step(1, 2'd0, 32'h0000_0021, 2'd0, "R11 one-shot entry");
        step(1, 2'd3, 32'h0, 2'd3, "R2 divide by 2");
        step(1, 2'd1, 32'd4, 2'd2, "R4 load");
        idle(12, "R3 divide by 2");
        step(1, 2'd3, 32'h3, 2'd3, "R2 divide by 16");
        step(1, 2'd1, 32'd3, 2'd2, "R4 load");
        idle(70, "R3 divide by 16");
        step(1, 2'd3, 32'h8, 2'd3, "R2 divide by 32");
        step(1, 2'd1, 32'd2, 2'd2, "R4 load");
        idle(100, "R3 divide by 32");
        step(1, 2'd3, 32'hA, 2'd3, "R2 divide by 128");
        step(1, 2'd1, 32'd1, 2'd2, "R4 load");
        idle(140, "R3 divide by 128");

        // R7: write to live count ignored
        step(1, 2'd3, 32'hB, 2'd3, "R2 divide by 1");
        step(1, 2'd1, 32'd20, 2'd2, "R4 load");
        idle(3, "R5 count");
        step(1, 2'd2, 32'hDEAD_BEEF, 2'd2, "R7 live write ignored");
        step(1, 2'd2, 32'd0, 2'd2, "R7 live write zero ignored");
        idle(3, "R7 count after write");

        // R4: restart mid-count
        step(1, 2'd1, 32'd6, 2'd2, "R4 restart mid-count");
        idle(9, "R4 count after restart");

        // R9: masked periodic keeps counting, no pulse
        step(1, 2'd0, 32'h0003_0077, 2'd0, "R11 masked periodic entry");
        step(1, 2'd1, 32'd2, 2'd2, "R4 load");
        idle(10, "R9 masked count");
        step(1, 2'd0, 32'h0002_0077, 2'd0, "R9 unmask");
        idle(6, "R9 unmasked count");

        // R10: start value 0 stays stopped
        step(1, 2'd1, 32'd0, 2'd2, "R10 load zero");
        idle(10, "R10 stopped");
        step(0, 2'd0, 0, 2'd1, "R10 start reads zero");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule